// File: doc/BRIEF.md
# IQ Serial Output Port

The port serialises complex sample pairs onto one data line. Each I/Q pair handed over with a load strobe is sent as one frame: the I word first, then the Q word, each most significant bit first. The word length is chosen from three settings. A frame-sync line marks each frame. It can be a single leading pulse, a level held across every data bit, or separate pulses ahead of each word.

The bit clock can come from two sources. As master, the port divides the system clock by a programmable ratio and drives the result out. As slave, it follows an external bit clock, which it synchronises into the system domain. Outputs change only at the rising edge of the bit clock, so a receiver samples them on the falling edge. A one-entry holding buffer takes a pair that arrives while a frame is still shifting, so the stream of frames can run without gaps. A data-ready pulse marks the start of each frame. Its width is either one bit-clock period or one system-clock cycle.

Top module: `iq_serial_port`

## Requirements
- R1: `word_len_i` selects the word width: 00 = 12 bits, 01 = 16 bits, 10 or 11 = 24 bits. The low bits of `i_data_i`, then of `q_data_i`, are sent on `sdo_o`, one bit per bit-clock period, starting with the top bit of the word (bit 11, 15 or 23).
- R2: With `fs_mode_i` = 00, `sdfs_o` is high for exactly one bit-clock period, and `sdo_o` is 0 during that period. The period sits immediately before the first I bit. `sdfs_o` is low for all data bits.
- R3: With `fs_mode_i` = 01, the frame has no leading slot, and `sdfs_o` is high for every I and Q data bit.
- R4: With `fs_mode_i` = 10 or 11, `sdfs_o` is high for one bit-clock period immediately before the first I bit and for one more immediately before the first Q bit. `sdo_o` is 0 in both of those periods.
- R5: With `master_i` high and `clk_div_i` = d, `sclk_o` has a period of d+1 system clocks and is high for ceil((d+1)/2) of them. For d = 0, `sclk_o` follows the system clock.
- R6: With `master_i` low, `sclk_o` stays 0, and the outputs advance on each rising edge of `ext_sclk_i` after a two-flop synchroniser. Reset always puts the port in slave mode.
- R7: `sdo_o` and `sdfs_o` change only at a rising bit-clock edge. With no frame in progress, both are 0.
- R8: A pair loaded during a frame is held and sent as the next frame, with no idle bit-clock period in between. A newer load overwrites a held pair that has not yet started.
- R9: At the start of each frame, `drdy_o` pulses high. The pulse lasts one bit-clock period when `map_rb_i` is low, and one system clock when `map_rb_i` is high.
- R10: Word length and frame-sync style are captured when a frame starts. Changing them later has no effect until the next frame.
- R11: While `rst_ni` is low, `sdo_o`, `sdfs_o`, `drdy_o` and `sclk_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| i_data_i | input | 24 | I word, right-aligned |
| q_data_i | input | 24 | Q word, right-aligned |
| load_i | input | 1 | One-cycle strobe to capture a pair |
| word_len_i | input | 2 | Word width select |
| fs_mode_i | input | 2 | Frame-sync style select |
| master_i | input | 1 | 1 = drive own bit clock, 0 = follow external |
| clk_div_i | input | 4 | Master divide ratio minus one |
| map_rb_i | input | 1 | Selects the system-clock-wide data-ready pulse |
| ext_sclk_i | input | 1 | External bit clock in slave mode |
| sdo_o | output | 1 | Serial data |
| sdfs_o | output | 1 | Frame sync |
| sclk_o | output | 1 | Bit clock in master mode, else 0 |
| drdy_o | output | 1 | Frame-start pulse |

## Verification
The assertions assume a few things about the inputs. The divide ratio and the readback-mapping select stay steady while a frame runs. The external bit clock holds each level for well over two system clocks. Loads arrive at least a full frame apart, unless the held-pair overwrite is being exercised on purpose. The stimulus applies reset before every configuration sweep point and keeps `clk_div_i` fixed through it. It toggles `ext_sclk_i` every six system clocks. Configuration changes while a frame is running occur only in the dedicated R8/R10 sequence.

// File: rtl/iqsp_pkg.sv
package iqsp_pkg;
  localparam int unsigned WORD_MAX = 24;
  localparam int unsigned BCNT_W   = $clog2(WORD_MAX + 1);

  typedef enum logic [2:0] {PH_IDLE, PH_PRE_I, PH_SH_I, PH_PRE_Q, PH_SH_Q} phase_e;

  localparam logic [1:0] FS_SINGLE = 2'b00;
  localparam logic [1:0] FS_ENV    = 2'b01;

  function automatic logic [BCNT_W-1:0] word_bits(input logic [1:0] code);
    case (code)
      2'b00:   return BCNT_W'(12);
      2'b01:   return BCNT_W'(16);
      default: return BCNT_W'(24);
    endcase
  endfunction

  function automatic logic [WORD_MAX-1:0] align_msb(input logic [WORD_MAX-1:0] d,
                                                     input logic [1:0] code);
    return d << (WORD_MAX - int'(word_bits(code)));
  endfunction
endpackage

// File: rtl/iqsp_sclk_gen.sv
module iqsp_sclk_gen #(
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ext_sclk_i,
  output logic             tick_o,
  output logic             sclk_o
);
  localparam int unsigned HW = DIV_W + 1;

  logic             master_q;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             sclk_q;
  logic             tick_m, tick_s;
  logic [HW-1:0]    hi_len;
  logic [SYNC_N-1:0] sync_q;
  logic             prev_q;

  assign tick_m = (cnt_q >= div_i);
  assign cnt_n  = tick_m ? '0 : cnt_q + 1'b1;
  assign hi_len = ({1'b0, div_i} + HW'(2)) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b0;
      cnt_q    <= '0;
      sclk_q   <= 1'b0;
      sync_q   <= '0;
      prev_q   <= 1'b0;
    end else begin
      master_q <= master_i;
      cnt_q    <= cnt_n;
      sclk_q   <= ({1'b0, cnt_n} < hi_len);
      sync_q   <= {sync_q[SYNC_N-2:0], ext_sclk_i};
      prev_q   <= sync_q[SYNC_N-1];
    end
  end

  assign tick_s = sync_q[SYNC_N-1] & ~prev_q;
  assign tick_o = master_q ? tick_m : tick_s;
  // divide-by-one passes the system clock straight through
  assign sclk_o = master_q ? ((div_i == '0) ? clk_i : sclk_q) : 1'b0;

  p_rise_at_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_q && (div_i != '0) && tick_m && $stable(div_i) |=> $rose(sclk_q));
  p_slave_tick_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_s |=> !tick_s);
endmodule

// File: rtl/iqsp_pair_buf.sv
module iqsp_pair_buf #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] i_i,
  input  logic [W-1:0] q_i,
  input  logic         take_i,
  output logic         valid_o,
  output logic [W-1:0] i_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      i_o     <= '0;
      q_o     <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      i_o     <= i_i;
      q_o     <= q_i;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !load_i && !take_i |=> valid_o && $stable(i_o) && $stable(q_o));
  p_take_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !load_i |=> !valid_o);
endmodule

// File: rtl/iqsp_framer.sv
module iqsp_framer
  import iqsp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                valid_i,
  input  logic [WORD_MAX-1:0] i_i,
  input  logic [WORD_MAX-1:0] q_i,
  input  logic [1:0]          wl_i,
  input  logic [1:0]          fs_i,
  output logic                take_o,
  output logic                sdo_o,
  output logic                fs_o,
  output logic                rdy_sclk_o,
  output logic                rdy_clk_o
);
  localparam int unsigned MSB = WORD_MAX - 1;

  phase_e              ph_q;
  logic [1:0]          wl_q, fsm_q;
  logic [BCNT_W-1:0]   cnt_q, bits;
  logic [WORD_MAX-1:0] isr_q, qsr_q, ai, aq;
  logic                last, env, start;

  assign bits  = word_bits(wl_q);
  assign last  = (cnt_q == bits - 1'b1);
  assign env   = (fsm_q == FS_ENV);
  assign start = tick_i && valid_i && ((ph_q == PH_IDLE) || (ph_q == PH_SH_Q && last));
  assign ai    = align_msb(i_i, wl_i);
  assign aq    = align_msb(q_i, wl_i);
  assign take_o = start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE; wl_q <= '0; fsm_q <= '0; cnt_q <= '0;
      isr_q <= '0; qsr_q <= '0; sdo_o <= 1'b0; fs_o <= 1'b0;
      rdy_sclk_o <= 1'b0; rdy_clk_o <= 1'b0;
    end else begin
      rdy_clk_o <= start;
      if (tick_i) begin
        rdy_sclk_o <= start;
        if (start) begin
          wl_q  <= wl_i;
          fsm_q <= fs_i;
          cnt_q <= '0;
          qsr_q <= aq;
          fs_o  <= 1'b1;
          if (fs_i == FS_ENV) begin
            ph_q <= PH_SH_I; sdo_o <= ai[MSB]; isr_q <= ai << 1;
          end else begin
            ph_q <= PH_PRE_I; sdo_o <= 1'b0; isr_q <= ai;
          end
        end else begin
          case (ph_q)
            PH_PRE_I: begin
              ph_q <= PH_SH_I; sdo_o <= isr_q[MSB]; isr_q <= isr_q << 1;
              fs_o <= 1'b0; cnt_q <= '0;
            end
            PH_SH_I: begin
              if (last) begin
                cnt_q <= '0;
                if (fsm_q[1]) begin
                  ph_q <= PH_PRE_Q; sdo_o <= 1'b0; fs_o <= 1'b1;
                end else begin
                  ph_q <= PH_SH_Q; sdo_o <= qsr_q[MSB]; qsr_q <= qsr_q << 1; fs_o <= env;
                end
              end else begin
                cnt_q <= cnt_q + 1'b1; sdo_o <= isr_q[MSB]; isr_q <= isr_q << 1; fs_o <= env;
              end
            end
            PH_PRE_Q: begin
              ph_q <= PH_SH_Q; sdo_o <= qsr_q[MSB]; qsr_q <= qsr_q << 1;
              fs_o <= 1'b0; cnt_q <= '0;
            end
            PH_SH_Q: begin
              if (last) begin
                ph_q <= PH_IDLE; sdo_o <= 1'b0; fs_o <= 1'b0;
              end else begin
                cnt_q <= cnt_q + 1'b1; sdo_o <= qsr_q[MSB]; qsr_q <= qsr_q << 1; fs_o <= env;
              end
            end
            default: begin
              ph_q <= PH_IDLE; sdo_o <= 1'b0; fs_o <= 1'b0;
            end
          endcase
        end
      end
    end
  end

  p_edge_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sdo_o) && $stable(fs_o));
  p_cnt_in_word_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SH_I || ph_q == PH_SH_Q) |-> cnt_q < bits);
  p_env_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SH_I || ph_q == PH_SH_Q) && env |-> fs_o);
  p_pulse_one_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && (ph_q == PH_PRE_I || ph_q == PH_PRE_Q) |=> !fs_o);
  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q == PH_IDLE |-> !sdo_o && !fs_o);
endmodule

// File: rtl/iq_serial_port.sv
module iq_serial_port
  import iqsp_pkg::*;
#(
  parameter int unsigned DIV_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WORD_MAX-1:0] i_data_i,
  input  logic [WORD_MAX-1:0] q_data_i,
  input  logic                load_i,
  input  logic [1:0]          word_len_i,
  input  logic [1:0]          fs_mode_i,
  input  logic                master_i,
  input  logic [DIV_W-1:0]    clk_div_i,
  input  logic                map_rb_i,
  input  logic                ext_sclk_i,
  output logic                sdo_o,
  output logic                sdfs_o,
  output logic                sclk_o,
  output logic                drdy_o
);
  logic                tick, take, bvalid, rdy_sclk, rdy_clk;
  logic [WORD_MAX-1:0] bi, bq;

  iqsp_sclk_gen #(.DIV_W(DIV_W), .SYNC_N(2)) u_sclk (
    .clk_i, .rst_ni, .master_i, .div_i(clk_div_i), .ext_sclk_i,
    .tick_o(tick), .sclk_o
  );

  iqsp_pair_buf #(.W(WORD_MAX)) u_buf (
    .clk_i, .rst_ni, .load_i, .i_i(i_data_i), .q_i(q_data_i),
    .take_i(take), .valid_o(bvalid), .i_o(bi), .q_o(bq)
  );

  iqsp_framer u_frm (
    .clk_i, .rst_ni, .tick_i(tick), .valid_i(bvalid), .i_i(bi), .q_i(bq),
    .wl_i(word_len_i), .fs_i(fs_mode_i), .take_o(take),
    .sdo_o, .fs_o(sdfs_o), .rdy_sclk_o(rdy_sclk), .rdy_clk_o(rdy_clk)
  );

  assign drdy_o = map_rb_i ? rdy_clk : rdy_sclk;

  p_drdy_narrow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_rb_i && drdy_o |=> !(map_rb_i && drdy_o));
endmodule

// File: tb/sim_iq_serial_port.sv
module sim_iq_serial_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, load = 1'b0, master = 1'b0, map_rb = 1'b0, ext_sclk = 1'b0;
  logic [23:0] i_d = '0, q_d = '0;
  logic [1:0]  wl = '0, fs = '0;
  logic [3:0]  div = '0;
  logic        sdo, sdfs, sclk, drdy;

  iq_serial_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .i_data_i(i_d), .q_data_i(q_d), .load_i(load),
    .word_len_i(wl), .fs_mode_i(fs), .master_i(master), .clk_div_i(div),
    .map_rb_i(map_rb), .ext_sclk_i(ext_sclk),
    .sdo_o(sdo), .sdfs_o(sdfs), .sclk_o(sclk), .drdy_o(drdy)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit got_d[$], got_f[$], exp_d[$], exp_f[$];
  bit mon_en = 0;

  // receiver: samples at the falling bit-clock edge
  initial begin
    bit prev = 0;
    int ecnt = 0;
    forever begin
      @(negedge clk);
      if (!mon_en) begin
        prev = 0; ecnt = 0; ext_sclk = 1'b0;
      end else if (master) begin
        if (div == 0 || (prev && !sclk)) begin got_d.push_back(sdo); got_f.push_back(sdfs); end
        prev = sclk;
      end else begin
        ecnt++;
        if (ecnt == 6) begin
          ecnt = 0;
          if (ext_sclk) begin got_d.push_back(sdo); got_f.push_back(sdfs); end
          ext_sclk = ~ext_sclk;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit m, input logic [1:0] w, input logic [1:0] f, input logic [3:0] d);
    mon_en = 0;
    @(negedge clk);
    master = m; wl = w; fs = f; div = d; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R11 and R6: everything quiet during reset, slave regardless of master_i
    chk({sdo, sdfs, drdy, sclk} == 4'b0, "R11", {sdo, sdfs, drdy, sclk}, 0);
    got_d.delete(); got_f.delete(); exp_d.delete(); exp_f.delete();
    rst_n = 1'b1;
    mon_en = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic load_pair(input logic [23:0] a, input logic [23:0] b);
    @(negedge clk);
    i_d = a; q_d = b; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic add_frame(input int w_code, input int f_code, input logic [23:0] a, input logic [23:0] b);
    int w;
    w = (w_code == 0) ? 12 : (w_code == 1) ? 16 : 24;
    if (f_code != 1) begin exp_d.push_back(0); exp_f.push_back(1); end
    for (int k = w - 1; k >= 0; k--) begin exp_d.push_back(a[k]); exp_f.push_back(f_code == 1); end
    if (f_code >= 2) begin exp_d.push_back(0); exp_f.push_back(1); end
    for (int k = w - 1; k >= 0; k--) begin exp_d.push_back(b[k]); exp_f.push_back(f_code == 1); end
  endtask

  task automatic check_stream(input string req);
    int st, bad, first;
    st = -1; bad = 0; first = -1;
    for (int k = 0; k < got_f.size(); k++) if (got_f[k] && st < 0) st = k;
    if (st < 0 || got_f.size() < st + exp_d.size() + 1) begin
      chk(0, req, got_f.size(), exp_d.size());
      return;
    end
    for (int k = 0; k < exp_d.size(); k++)
      if (got_d[st+k] != exp_d[k] || got_f[st+k] != exp_f[k]) begin
        bad++; if (first < 0) first = k;
      end
    chk(bad == 0, req, first, -1);
    // R7: idle after the last frame
    chk(!got_d[st+exp_d.size()] && !got_f[st+exp_d.size()], "R7 idle",
        {got_d[st+exp_d.size()], got_f[st+exp_d.size()]}, 0);
  endtask

  task automatic wait_slots(input int per);
    repeat ((exp_d.size() + 6) * per + 20) @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int dv[4] = '{0, 1, 4, 15};
    logic [23:0] a, b;
    int hi, cnt;

    // R1..R4 with R5 data timing: master sweep
    for (int w = 0; w < 4; w++)
      for (int f = 0; f < 4; f++)
        for (int j = 0; j < 4; j++) begin
          do_reset(1, 2'(w), 2'(f), 4'(dv[j]));
          a = 24'h9c35a1 ^ 24'(w * 24'h111111 + f * 24'h0f0f07 + j * 24'h3);
          b = ~a ^ 24'(j * 24'h5a5a5);
          load_pair(a, b);
          add_frame(w, f, a, b);
          wait_slots(dv[j] + 1);
          check_stream(f == 0 ? "R1 R2" : f == 1 ? "R1 R3" : "R1 R4");
        end

    // R6: slave mode follows external bit clock
    for (int w = 0; w < 4; w++) begin
      do_reset(0, 2'(w), 2'b00, 4'd3);
      a = 24'h5e1d27 + 24'(w * 24'h13579);
      b = 24'ha0f3c6 - 24'(w * 24'h2468a);
      load_pair(a, b);
      add_frame(w, 0, a, b);
      wait_slots(12);
      check_stream("R6");
      chk(sclk == 1'b0, "R6 sclk", sclk, 0);
    end

    // R5: duty and period for divide ratios 2..16
    for (int d = 1; d < 16; d++) begin
      do_reset(1, 2'b00, 2'b00, 4'(d));
      repeat (10) @(negedge clk);
      hi = 0;
      for (int k = 0; k < 4 * (d + 1); k++) begin @(negedge clk); if (sclk) hi++; end
      chk(hi == 4 * ((d + 2) / 2), "R5", hi, 4 * ((d + 2) / 2));
    end

    // R9: data-ready width in both settings, divide ratio 5
    for (int m = 0; m < 2; m++) begin
      map_rb = 1'(m);
      do_reset(1, 2'b00, 2'b00, 4'd4);
      load_pair(24'h123456, 24'h654321);
      cnt = 0;
      for (int k = 0; k < 300; k++) begin @(negedge clk); if (drdy) cnt++; end
      chk(cnt == (m ? 1 : 5), "R9", cnt, m ? 1 : 5);
    end
    map_rb = 1'b0;

    // R8 and R10: buffered pair, overwrite, config captured per frame
    do_reset(1, 2'b00, 2'b00, 4'd1);
    load_pair(24'h0003a7, 24'h000c59);
    repeat (8) @(negedge clk);
    wl = 2'b01; fs = 2'b10;
    load_pair(24'h00beef, 24'h00f00d);
    load_pair(24'h00c0de, 24'h007e57);
    add_frame(0, 0, 24'h0003a7, 24'h000c59);
    add_frame(1, 2, 24'h00c0de, 24'h007e57);
    wait_slots(2);
    check_stream("R8 R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule